// File: doc/BRIEF.md
# Random TLB Replacement Index Generator

This block supplies the index of the TLB entry to overwrite when software asks for a random replacement. The top region of the TLB is selectable: entries below a wired boundary are reserved and are never chosen. Each request produces one index in the range from the wired boundary up to the last entry. The same index is never produced twice in a row.

A 32-bit Galois LFSR is the source of randomness. For each attempt the LFSR takes one step and its new value is reduced modulo the size of the free region by a bit-serial restoring divider, one dividend bit per cycle. The wired count is then added to the remainder. If the result matches the index returned last time, the LFSR steps again and the reduction restarts. A wired count that leaves one free entry or none skips the generator and answers at once with the last entry. A busy output covers the whole computation, and a request made while busy is dropped.

Top module: `rand_index_gen`

## Requirements
- R1: After reset, valid_o and busy_o are 0 and index_o is 0. The remembered previous index is 0 and the LFSR holds 1.
- R2: An LFSR step shifts the 32-bit state right by one place. When the bit shifted out is 1, the result is then XORed with 0xD0000001. Every attempt takes exactly one step before it reduces.
- R3: With wired_i below ENTRIES-1, a candidate equals (LFSR value mod (ENTRIES - wired)) + wired. The returned index therefore lies between wired and ENTRIES-1, inclusive.
- R4: When a candidate equals the previously returned index, it is discarded and another attempt follows. The index given with valid_o differs from the one returned before it.
- R5: When wired_i is ENTRIES-1 or larger, the result is ENTRIES-1. It is given with valid_o one cycle after the request, and the LFSR does not step.
- R6: In the normal path, busy_o is 1 from the cycle after an accepted request until valid_o appears. While busy_o is 1, req_i is ignored and neither the LFSR nor any later result is affected.
- R7: valid_o is a one-cycle pulse per accepted request. index_o holds its value until the next valid_o.
- R8: wired_i is sampled when the request is accepted. Later changes to it do not affect that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe for a new index, taken only while idle |
| wired_i | input | WIRED_W | Number of reserved low entries |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | One-cycle pulse: index_o carries a new result |
| index_o | output | IDX_W | Last returned index |

## Verification
The bench builds the block with ENTRIES=12, which is not a power of two. The modulo is therefore a true remainder and not a bit mask. A 4-bit wired input can also reach 12 and 15, past the table end, so the degenerate path covers both a boundary equal to the entry count and one above it. A wired value of 10 leaves only two free entries, which makes repeat rejections and multiple attempts frequent. A reference LFSR in the bench follows every step, so one extra or missing step in either path shows up in later results.

// File: rtl/rig_pkg.sv
package rig_pkg;
    localparam logic [31:0] LFSR_TAPS = 32'hD000_0001;
    localparam logic [31:0] LFSR_SEED = 32'h0000_0001;

    function automatic logic [31:0] lfsr_advance(input logic [31:0] cur);
        lfsr_advance = (cur >> 1) ^ (cur[0] ? LFSR_TAPS : 32'h0);
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_WAIT = 2'd2
    } rig_state_e;
endpackage

// File: rtl/rig_lfsr.sv
module rig_lfsr
    import rig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    output logic [31:0] nxt_o
);
    logic [31:0] state_d, state_q;

    always_comb begin
        nxt_o   = lfsr_advance(state_q);
        state_d = step_i ? nxt_o : state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LFSR_SEED;
        else        state_q <= state_d;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'h0); // R2
endmodule

// File: rtl/rig_mod.sv
module rig_mod #(
    parameter int DIV_W = 5,
    parameter int NUM_W = 32,
    localparam int RW    = DIV_W + 1,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             done_o,
    output logic [DIV_W-1:0] rem_o
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] sh;
        logic [RW-1:0]    rem;
    } mod_st_t;

    mod_st_t d, q;
    logic [RW-1:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem[RW-2:0], q.sh[NUM_W-1]};
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(NUM_W);
            d.sh   = num_i;
            d.rem  = '0;
        end else if (q.busy) begin
            d.rem = (trial >= RW'(div_i)) ? trial - RW'(div_i) : trial;
            d.sh  = q.sh << 1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign rem_o  = q.rem[DIV_W-1:0];

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (RW'(rem_o) < RW'(div_i))); // R3
    AST_REM_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !q.rem[RW-1]); // R3
endmodule

// File: rtl/rand_index_gen.sv
module rand_index_gen
    import rig_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WIRED_W = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [WIRED_W-1:0] wired_i,
    output logic               busy_o,
    output logic               valid_o,
    output logic [IDX_W-1:0]   index_o
);
    localparam logic [WIRED_W-1:0] LAST_W  = WIRED_W'(ENTRIES - 1);
    localparam logic [WIRED_W-1:0] COUNT_W = WIRED_W'(ENTRIES);
    localparam logic [IDX_W-1:0]   LAST_I  = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        rig_state_e         st;
        logic [WIRED_W-1:0] wired;
        logic               deg;
        logic               valid;
        logic [IDX_W-1:0]   idx;
    } top_st_t;

    top_st_t d, q;
    logic               step;
    logic [31:0]        lfsr_nxt;
    logic               mod_done;
    logic [WIRED_W-1:0] mod_rem;
    logic [WIRED_W-1:0] range;
    logic [WIRED_W:0]   cand_w;
    logic [IDX_W-1:0]   cand;

    rig_lfsr u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .nxt_o  (lfsr_nxt)
    );

    rig_mod #(.DIV_W(WIRED_W), .NUM_W(32)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (step),
        .num_i   (lfsr_nxt),
        .div_i   (range),
        .done_o  (mod_done),
        .rem_o   (mod_rem)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        step    = 1'b0;
        range   = COUNT_W - q.wired;
        cand_w  = {1'b0, mod_rem} + {1'b0, q.wired};
        cand    = cand_w[IDX_W-1:0];
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.wired = wired_i;
                    if (wired_i >= LAST_W) begin
                        d.deg   = 1'b1;
                        d.valid = 1'b1;
                        d.idx   = LAST_I;
                    end else begin
                        d.deg = 1'b0;
                        d.st  = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                step = 1'b1;
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mod_done) begin
                    if (cand == q.idx) begin
                        d.st = ST_STEP;
                    end else begin
                        d.idx   = cand;
                        d.valid = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.wired <= '0;
            q.deg   <= 1'b0;
            q.valid <= 1'b0;
            q.idx   <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.st != ST_IDLE);
    assign valid_o = q.valid;
    assign index_o = q.idx;

    AST_IDX_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (index_o <= LAST_I)); // R3
    AST_IDX_ABOVE_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !q.deg) |-> (WIRED_W'(index_o) >= q.wired)); // R3
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !q.deg) |-> (index_o != $past(index_o))); // R4
    AST_DEG_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && q.deg) |-> (index_o == LAST_I)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(index_o)); // R7
    AST_BUSY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !valid_o); // R6
endmodule

// File: tb/sim_rand_index_gen.sv
module sim_rand_index_gen;
    localparam int E       = 12;
    localparam int IDX_W   = $clog2(E);
    localparam int WIRED_W = $clog2(E + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req = 1'b0;
    logic [WIRED_W-1:0] wired = '0;
    logic               busy, valid;
    logic [IDX_W-1:0]   index;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_lfsr = 32'h1;
    int          m_prev = 0;

    rand_index_gen #(.ENTRIES(E)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wired_i(wired),
        .busy_o(busy), .valid_o(valid), .index_o(index)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_next(input int w);
        int idx;
        if (w >= E - 1) begin
            m_prev = E - 1;
            return E - 1;
        end
        do begin
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'hD000_0001 : 32'h0);
            idx = int'(m_lfsr % (E - w)) + w;
        end while (idx == m_prev);
        m_prev = idx;
        return idx;
    endfunction

    // Request with wired w; optional poke of req/wired while busy.
    task automatic do_req(input int w, input string tag, input bit poke, input bit wchg);
        int exp, n, extra;
        bit busy_ok;
        exp = model_next(w);
        @(negedge clk);
        req = 1'b1; wired = WIRED_W'(w);
        @(negedge clk);
        req = 1'b0;
        if (wchg) wired = '0;
        n = 0; extra = 0; busy_ok = 1'b1;
        if (w >= E - 1) begin
            check({tag, " R5 immediate valid"}, int'(valid), 1);
            check({tag, " R5 no busy"}, int'(busy), 0);
        end else begin
            check({tag, " R6 busy after accept"}, int'(busy), 1);
            while (!valid && n < 5000) begin
                if (!busy) busy_ok = 1'b0;
                if (poke && n == 10) req = 1'b1;
                if (poke && n == 11) req = 1'b0;
                @(negedge clk);
                n++;
            end
            check({tag, " R6 busy held until valid"}, int'(busy_ok), 1);
            check({tag, " R7 valid seen"}, int'(valid), 1);
        end
        check({tag, " R3 index value"}, int'(index), exp);
        check({tag, " R3 index range"}, int'(index >= IDX_W'(w > E - 1 ? E - 1 : w) && index <= IDX_W'(E - 1)), 1);
        @(negedge clk);
        check({tag, " R7 valid one cycle"}, int'(valid), 0);
        repeat (40) begin
            @(negedge clk);
            if (valid) extra++;
        end
        check({tag, " R6 no extra result"}, extra, 0);
        check({tag, " R7 index held"}, int'(index), exp);
    endtask

    task automatic t_reset;
        check("R1 valid after reset", int'(valid), 0);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 index after reset", int'(index), 0);
    endtask

    task automatic t_wired_zero;
        for (int i = 0; i < 6; i++) do_req(0, "R2 wired0", 1'b0, 1'b0);
    endtask

    task automatic t_wired_mid;
        for (int i = 0; i < 6; i++) do_req(5, "R3 wired5", 1'b0, 1'b0);
    endtask

    task automatic t_narrow;
        for (int i = 0; i < 8; i++) do_req(10, "R4 wired10", 1'b0, 1'b0);
    endtask

    task automatic t_degenerate;
        do_req(11, "R5 wired11", 1'b0, 1'b0);
        do_req(12, "R5 wired12", 1'b0, 1'b0);
        do_req(15, "R5 wired15", 1'b0, 1'b0);
        do_req(3, "R5 lfsr untouched", 1'b0, 1'b0);
    endtask

    task automatic t_busy_ignore;
        for (int i = 0; i < 3; i++) do_req(2, "R6 req while busy", 1'b1, 1'b0);
    endtask

    task automatic t_wired_latch;
        for (int i = 0; i < 3; i++) do_req(7, "R8 wired latched", 1'b0, 1'b1);
    endtask

    initial begin
        fork
            begin
                #4;
                t_reset;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_wired_zero;
                t_wired_mid;
                t_narrow;
                t_degenerate;
                t_busy_ignore;
                t_wired_latch;
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule